// File: doc/BRIEF.md
# Serial CAM Address Filter

This block sits next to an Ethernet receiver and decides whether an incoming frame should be thrown away. It watches the serial receive stream one bit per clock. A one-bit-time start strobe marks the second bit of the destination address. The block recovers the first bit with a one-cycle delay register and shifts in the whole destination address least-significant bit first. It then asks an external content-addressable memory whether that address is known.

The block only ever acts to reject a frame. When the memory reports a miss, or stays silent for longer than a set number of bit times, the block raises the reject output. Reject stays high until the receive enable falls at the end of the frame. When the memory reports a hit, nothing happens. If the receive enable drops early, which signals a collision, the block abandons capture or the pending compare and stays quiet.

The block is clocked by the receive bit clock, so one clock cycle is one bit time.

Top module: `cam_addr_filter`

## Requirements
- R1: After reset, `reject` and `cam_req` are low.
- R2: `cam_key` bit i holds the i-th received destination bit, with bit 0 being the bit sampled one bit time before `rx_start` and bit 1 the bit sampled with it; all `ADDR_W` bits are captured.
- R3: `cam_req` rises in the cycle after the last address bit is sampled, and stays high until `cam_valid`, a timeout, or an abort.
- R4: A compare answered with `cam_valid` and `cam_hit` high leaves `reject` low for the rest of the frame.
- R5: A compare answered with `cam_valid` high and `cam_hit` low raises `reject` in the cycle after the answer.
- R6: If `cam_req` has been high for `TIMEOUT` cycles with no `cam_valid`, `reject` rises.
- R7: `rx_en` low during capture or during a pending compare aborts the frame: `cam_req` drops the next cycle and no reject is issued.
- R8: Once high, `reject` holds while `rx_en` stays high, and it is low in the cycle after `rx_en` falls. `reject` never rises while `rx_en` is low.
- R9: An `rx_start` pulse that arrives while a frame is already being handled is ignored, and the captured key is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 1 | Serial receive data, least-significant bit first |
| rx_start | input | 1 | One-cycle strobe on the second destination bit |
| rx_en | input | 1 | Receive enable, high for the duration of a frame |
| cam_req | output | 1 | Compare request, held until answered |
| cam_key | output | ADDR_W | Captured destination address to look up |
| cam_valid | input | 1 | One-cycle answer strobe from the memory |
| cam_hit | input | 1 | Lookup result, valid with cam_valid |
| reject | output | 1 | Discard the current frame |

## Verification
On every cycle the assertions check the following: the request holds while unanswered, a miss or a timeout leads to reject one cycle later, a hit keeps reject low, an early drop of the enable silences both outputs, and reject holds until the frame ends. Only the bench scenarios can show that the captured key matches the transmitted address bit for bit, including the bit recovered from before the strobe. The same applies to a stray strobe inside a frame leaving the key untouched and to each frame's final outcome matching what a behavioural lookup table predicts.

// File: rtl/cam_filter_pkg.sv
package cam_filter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAPT = 3'd1,
    ST_WAIT = 3'd2,
    ST_PASS = 3'd3,
    ST_DROP = 3'd4
  } filt_state_t;
endpackage

// File: rtl/cam_addr_shift.sv
module cam_addr_shift #(
  parameter int ADDR_W = 48,
  localparam int CNT_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data,
  input  logic              load,
  input  logic              shift,
  output logic [ADDR_W-1:0] key,
  output logic              last_bit
);
  logic             prev_bit;
  logic [CNT_W-1:0] bit_cnt;

  // Strobe cycle: the delayed bit and the current bit enter together.
  function automatic logic [ADDR_W-1:0] seed_key(input logic [ADDR_W-1:0] sr,
                                                 input logic prev, input logic cur);
    return {cur, prev, sr[ADDR_W-1:2]};
  endfunction

  // Later bits enter at the top and move toward bit 0.
  function automatic logic [ADDR_W-1:0] shift_key(input logic [ADDR_W-1:0] sr,
                                                  input logic b);
    return {b, sr[ADDR_W-1:1]};
  endfunction

  assign last_bit = shift && (bit_cnt == CNT_W'(ADDR_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit <= 1'b0;
      key      <= '0;
      bit_cnt  <= '0;
    end else begin
      prev_bit <= rx_data;
      if (load) begin
        key     <= seed_key(key, prev_bit, rx_data);
        bit_cnt <= CNT_W'(2);
      end else if (shift) begin
        key     <= shift_key(key, rx_data);
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_wait_timer.sv
module cam_wait_timer #(
  parameter int TIMEOUT = 16,
  localparam int CNT_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end
endmodule

// File: rtl/cam_match_fsm.sv
module cam_match_fsm
  import cam_filter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_start,
  input  logic rx_en,
  input  logic last_bit,
  input  logic cam_valid,
  input  logic cam_hit,
  input  logic tmo,
  output logic load,
  output logic shift,
  output logic waiting,
  output logic reject
);
  filt_state_t state, nxt;

  assign load    = (state == ST_IDLE) && rx_start && rx_en;
  assign shift   = (state == ST_CAPT) && rx_en;
  assign waiting = (state == ST_WAIT);
  assign reject  = (state == ST_DROP);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (load) nxt = ST_CAPT;
      ST_CAPT: begin
        if (!rx_en)        nxt = ST_IDLE;
        else if (last_bit) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (!rx_en)         nxt = ST_IDLE;
        else if (cam_valid) nxt = cam_hit ? ST_PASS : ST_DROP;
        else if (tmo)       nxt = ST_DROP;
      end
      ST_PASS, ST_DROP: if (!rx_en) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/cam_addr_filter.sv
module cam_addr_filter #(
  parameter int ADDR_W  = 48,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data,
  input  logic              rx_start,
  input  logic              rx_en,
  output logic              cam_req,
  output logic [ADDR_W-1:0] cam_key,
  input  logic              cam_valid,
  input  logic              cam_hit,
  output logic              reject
);
  // Internal events, named for the checker.
  logic ev_load;
  logic ev_shift;
  logic ev_cap_done;
  logic ev_timeout;

  cam_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_data  (rx_data),
    .load     (ev_load),
    .shift    (ev_shift),
    .key      (cam_key),
    .last_bit (ev_cap_done)
  );

  cam_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cam_req),
    .expire (ev_timeout)
  );

  cam_match_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_start  (rx_start),
    .rx_en     (rx_en),
    .last_bit  (ev_cap_done),
    .cam_valid (cam_valid),
    .cam_hit   (cam_hit),
    .tmo       (ev_timeout),
    .load      (ev_load),
    .shift     (ev_shift),
    .waiting   (cam_req),
    .reject    (reject)
  );
endmodule

// File: rtl/cam_addr_filter_chk.sv
module cam_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic cam_req,
  input logic cam_valid,
  input logic cam_hit,
  input logic reject,
  input logic cap_done,
  input logic tmo
);
  p_req_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && rx_en |=> cam_req);

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cam_req && !cam_valid && !tmo && rx_en |=> cam_req);

  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cam_req && cam_valid && cam_hit |=> !reject);

  p_miss_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cam_req && cam_valid && !cam_hit && rx_en |=> reject);

  p_timeout_rejects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo && !cam_valid && rx_en |=> reject);

  p_abort_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !cam_req && !reject);

  p_reject_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject && rx_en |=> reject);

  p_reject_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reject) |-> rx_en);
endmodule

bind cam_addr_filter cam_addr_filter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .cam_req   (cam_req),
  .cam_valid (cam_valid),
  .cam_hit   (cam_hit),
  .reject    (reject),
  .cap_done  (ev_cap_done),
  .tmo       (ev_timeout)
);

// File: tb/cam_addr_filter_tb.sv
module cam_addr_filter_tb;
  localparam int AW  = 48;
  localparam int TMO = 16;
  localparam logic [AW-1:0] KNOWN_A = 48'h0A1B_2C3D_4E5F;
  localparam logic [AW-1:0] KNOWN_B = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data = 1'b0, rx_start = 1'b0, rx_en = 1'b0;
  logic cam_valid = 1'b0, cam_hit = 1'b0;
  logic cam_req, reject;
  logic [AW-1:0] cam_key;

  int checks = 0, errors = 0, cycles = 0;
  bit cam_mute = 1'b0;
  int lat_cnt = 0;
  logic [AW-1:0] q_key[$];
  bit q_rej[$];

  always #5 clk = ~clk;

  cam_addr_filter #(.ADDR_W(AW), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_start(rx_start),
    .rx_en(rx_en), .cam_req(cam_req), .cam_key(cam_key),
    .cam_valid(cam_valid), .cam_hit(cam_hit), .reject(reject)
  );

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural lookup memory with fixed latency.
  always @(negedge clk) begin
    cam_valid <= 1'b0;
    if (cam_req && !cam_valid && !cam_mute) begin
      if (lat_cnt == 3) begin
        cam_valid <= 1'b1;
        cam_hit   <= (cam_key == KNOWN_A) || (cam_key == KNOWN_B);
        lat_cnt   <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
  end

  // Monitor: samples 2 ns after each rising edge.
  bit prev_en = 1'b0, prev_req = 1'b0, saw_rej = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (rx_en && reject) saw_rej = 1'b1;
      if (cam_req && !prev_req) begin
        if (q_key.size() == 0) check(1'b0, "R7 unexpected request", cam_key, '0);
        else begin
          logic [AW-1:0] k;
          k = q_key.pop_front();
          check(cam_key == k, "R2/R9 captured key", cam_key, k);
        end
      end
      if (cam_valid && rx_en)
        check(reject == !cam_hit, cam_hit ? "R4 hit keeps reject low" : "R5 miss rejects next cycle",
              AW'(reject), AW'(!cam_hit));
      if (prev_en && !rx_en) begin
        bit e;
        e = q_rej.size() ? q_rej.pop_front() : 1'b0;
        check(saw_rej == e, "R4/R5/R6/R7 frame outcome", AW'(saw_rej), AW'(e));
        check(reject == 1'b0, "R8 reject cleared after frame end", AW'(reject), '0);
        saw_rej = 1'b0;
      end
      prev_en  = rx_en;
      prev_req = cam_req;
    end
  end

  // Driver: cut < 0 means the frame runs to its end.
  task automatic send_frame(input logic [AW-1:0] addr, input int pay, input int cut,
                            input bit stray, input bit exp_req, input bit exp_rej);
    if (exp_req) q_key.push_back(addr);
    q_rej.push_back(exp_rej);
    @(negedge clk); rx_en = 1'b1; rx_data = 1'b1;
    @(negedge clk); rx_data = 1'b0;
    for (int i = 0; i < AW + pay; i++) begin
      if (i == cut) break;
      @(negedge clk);
      rx_data  = (i < AW) ? addr[i] : 1'($urandom);
      rx_start = (i == 1) || (stray && i == 20);
    end
    @(negedge clk); rx_en = 1'b0; rx_start = 1'b0; rx_data = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reject == 1'b0 && cam_req == 1'b0, "R1 reset state",
          AW'({cam_req, reject}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(KNOWN_A, 20, -1, 1'b0, 1'b1, 1'b0);              // R4 hit
    send_frame(48'h1234_5678_9ABC, 20, -1, 1'b0, 1'b1, 1'b1);   // R5 miss
    send_frame(48'h8000_0000_0001, 20, -1, 1'b0, 1'b1, 1'b1);   // R2 end bits
    send_frame(KNOWN_B, 20, -1, 1'b0, 1'b1, 1'b0);              // R4 all ones
    send_frame(48'h5555_AAAA_3333, 20, -1, 1'b1, 1'b1, 1'b1);   // R9 stray strobe
    send_frame(KNOWN_A, 30, 30, 1'b0, 1'b0, 1'b0);              // R7 abort in capture
    cam_mute = 1'b1;
    send_frame(48'h0000_0000_0002, 30, -1, 1'b0, 1'b1, 1'b1);   // R6 timeout
    send_frame(KNOWN_A, 30, 52, 1'b0, 1'b1, 1'b0);              // R7 abort in wait
    cam_mute = 1'b0;
    send_frame(48'hDEAD_BEEF_0042, 20, -1, 1'b0, 1'b1, 1'b1);   // R3 after abort
    check(q_key.size() == 0, "R3 all requests seen", AW'(q_key.size()), '0);
    check(q_rej.size() == 0, "R8 all frames ended", AW'(q_rej.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      check(1'b0, "watchdog", AW'(cycles), '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule